// File: doc/BRIEF.md
# Double-Precision Subtract Special-Operand Resolver

This block sits in front of a floating-point subtract datapath. It looks at the two 64-bit binary64 operands of x − y and works out each operand's class: zero, normal, denormal, infinity, quiet NaN or signaling NaN. From the pair of classes it decides whether the difference can be settled without arithmetic. When it can, the block gives the final 64-bit result. It also raises an invalid-operation flag whenever a NaN is produced from nothing or a signaling NaN is consumed.

When both operands are finite and nonzero, the block produces no result. Instead it asserts a "go to datapath" signal. It also marks which operand is denormal and so needs normalising before alignment. A 2-bit rounding-mode input matters in only one case: the sign of an exact zero from subtracting equal zeros. All outputs are registered, so a decision appears one clock after its operands are presented.

Top module: `fpsub_special`

## Requirements
- R1: When either operand is a signaling NaN, `invalid_o` is 1 and `res_o` equals the default NaN (parameter, default 64'h7FF8_0000_0000_0000). A signaling NaN has an all-ones exponent (bits 62:52), fraction bit 51 clear and a nonzero fraction. This rule wins over every other rule.
- R2: When one operand is a quiet NaN (all-ones exponent, fraction bit 51 set) and the other is not a signaling NaN, `res_o` is that quiet NaN bit for bit. When both are quiet NaNs, x is returned. `invalid_o` is 0.
- R3: For infinity minus infinity, equal signs give `invalid_o`=1 and the default NaN. Opposite signs return x with `invalid_o`=0.
- R4: A finite or zero x minus an infinite y yields an infinity whose sign bit (bit 63) is the inverse of y's sign.
- R5: An infinite x minus a finite or zero y returns x unchanged.
- R6: Zero minus zero with opposite signs returns x. With equal signs it returns a zero whose sign bit is 1 only when `rm_i` is 2'b11 (toward −infinity). The encodings 2'b00 nearest, 2'b01 toward zero and 2'b10 toward +infinity give +0.
- R7: A nonzero finite x minus a zero y (either sign) returns x unchanged.
- R8: A zero x minus a nonzero finite y returns y with bit 63 inverted.
- R9: When both operands are nonzero finite, `use_dp_o`=1, `res_o`=0 and `invalid_o`=0. `norm_x_o` and `norm_y_o` are 1 exactly for an operand with a zero exponent field. In every other case the three flags are 0.
- R10: Outputs reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low, all outputs are 0.
- R11: `invalid_o` is never 1 unless `res_o` holds the default NaN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| x_i | input | 64 | Minuend, binary64 |
| y_i | input | 64 | Subtrahend, binary64 |
| rm_i | input | 2 | Rounding mode: 00 nearest, 01 toward zero, 10 toward +inf, 11 toward −inf |
| res_o | output | 64 | Resolved result (0 when the datapath is needed) |
| invalid_o | output | 1 | Invalid-operation flag |
| use_dp_o | output | 1 | Pair must be handled by the arithmetic datapath |
| norm_x_o | output | 1 | x is denormal and needs normalising |
| norm_y_o | output | 1 | y is denormal and needs normalising |

## Verification
The bench targets the priority among NaNs. A signaling NaN paired with a quiet NaN must still give the default NaN, and a design that checked quiet NaNs first would pass the quiet payload through with no flag. It applies infinity minus infinity in both sign combinations, since swapping the equal-sign and opposite-sign branches would flag a legal result and pass an illegal one. Zero minus zero is run under all four rounding modes and under mixed signs, which exposes a wrong mode decode or a sign taken from y instead of x. Zero minus a finite operand, finite minus zero, and denormal pairings catch a missing sign inversion and mis-set normalisation flags.

// File: rtl/fpsub_pkg.sv
package fpsub_pkg;

    typedef enum logic [2:0] {
        CL_ZERO  = 3'd0,
        CL_NORM  = 3'd1,
        CL_DNORM = 3'd2,
        CL_INF   = 3'd3,
        CL_QNAN  = 3'd4,
        CL_SNAN  = 3'd5
    } opclass_e;

    localparam logic [1:0] RM_NEAR = 2'b00;
    localparam logic [1:0] RM_ZERO = 2'b01;
    localparam logic [1:0] RM_UP   = 2'b10;
    localparam logic [1:0] RM_DOWN = 2'b11;

endpackage

// File: rtl/fpsub_classify.sv
module fpsub_classify
    import fpsub_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] op_i,
    output logic         sign_o,
    output opclass_e     cls_o
);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_max;
    logic              exp_min;
    logic              frac_nz;

    always_comb begin
        sign_o  = op_i[W-1];
        exp_f   = op_i[W-2 -: EXP_W];
        frac_f  = op_i[FRAC_W-1:0];
        exp_max = &exp_f;
        exp_min = ~|exp_f;
        frac_nz = |frac_f;
        if (exp_max) begin
            if (!frac_nz)               cls_o = CL_INF;
            else if (frac_f[FRAC_W-1])  cls_o = CL_QNAN;
            else                        cls_o = CL_SNAN;
        end else if (exp_min) begin
            cls_o = frac_nz ? CL_DNORM : CL_ZERO;
        end else begin
            cls_o = CL_NORM;
        end
    end

endmodule

// File: rtl/fpsub_resolve.sv
module fpsub_resolve
    import fpsub_pkg::*;
#(
    parameter int EXP_W                 = 11,
    parameter int FRAC_W                = 52,
    localparam int W                    = 1 + EXP_W + FRAC_W,
    parameter logic [W-1:0] DEFAULT_NAN = 64'h7FF8_0000_0000_0000
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  opclass_e     xcls_i,
    input  opclass_e     ycls_i,
    input  logic         xs_i,
    input  logic         ys_i,
    input  logic [1:0]   rm_i,
    output logic [W-1:0] val_o,
    output logic         inv_o,
    output logic         dp_o,
    output logic         nx_o,
    output logic         ny_o
);

    logic x_fin;
    logic y_fin;
    logic x_zero;
    logic y_zero;

    always_comb begin
        x_zero = (xcls_i == CL_ZERO);
        y_zero = (ycls_i == CL_ZERO);
        x_fin  = (xcls_i == CL_NORM) || (xcls_i == CL_DNORM);
        y_fin  = (ycls_i == CL_NORM) || (ycls_i == CL_DNORM);

        val_o = '0;
        inv_o = 1'b0;
        dp_o  = 1'b0;
        nx_o  = 1'b0;
        ny_o  = 1'b0;

        if (xcls_i == CL_SNAN || ycls_i == CL_SNAN) begin
            inv_o = 1'b1;
            val_o = DEFAULT_NAN;
        end else if (xcls_i == CL_QNAN) begin
            val_o = x_i;
        end else if (ycls_i == CL_QNAN) begin
            val_o = y_i;
        end else if (xcls_i == CL_INF && ycls_i == CL_INF) begin
            if (xs_i == ys_i) begin
                inv_o = 1'b1;
                val_o = DEFAULT_NAN;
            end else begin
                val_o = x_i;
            end
        end else if (ycls_i == CL_INF) begin
            val_o = {~ys_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (xcls_i == CL_INF) begin
            val_o = x_i;
        end else if (x_zero && y_zero) begin
            if (xs_i != ys_i) val_o = x_i;
            else              val_o = {(rm_i == RM_DOWN), {(W-1){1'b0}}};
        end else if (y_zero) begin
            val_o = x_i;
        end else if (x_zero) begin
            val_o = {~ys_i, y_i[W-2:0]};
        end else if (x_fin && y_fin) begin
            dp_o = 1'b1;
            nx_o = (xcls_i == CL_DNORM);
            ny_o = (ycls_i == CL_DNORM);
        end
    end

endmodule

// File: rtl/fpsub_special.sv
module fpsub_special
    import fpsub_pkg::*;
#(
    parameter int EXP_W                 = 11,
    parameter int FRAC_W                = 52,
    localparam int W                    = 1 + EXP_W + FRAC_W,
    parameter logic [W-1:0] DEFAULT_NAN = 64'h7FF8_0000_0000_0000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [1:0]   rm_i,
    output logic [W-1:0] res_o,
    output logic         invalid_o,
    output logic         use_dp_o,
    output logic         norm_x_o,
    output logic         norm_y_o
);

    localparam int NOPS = 2;

    typedef struct packed {
        logic [W-1:0] res;
        logic         inv;
        logic         dp;
        logic         nx;
        logic         ny;
    } out_t;

    logic [W-1:0] ops    [NOPS];
    logic         sgn    [NOPS];
    opclass_e     cls    [NOPS];

    logic [W-1:0] r_val;
    logic         r_inv;
    logic         r_dp;
    logic         r_nx;
    logic         r_ny;

    out_t out_d;
    out_t out_q;

    assign ops[0] = x_i;
    assign ops[1] = y_i;

    for (genvar gi = 0; gi < NOPS; gi++) begin : g_cls
        fpsub_classify #(
            .EXP_W (EXP_W),
            .FRAC_W(FRAC_W)
        ) u_classify (
            .op_i  (ops[gi]),
            .sign_o(sgn[gi]),
            .cls_o (cls[gi])
        );
    end

    fpsub_resolve #(
        .EXP_W      (EXP_W),
        .FRAC_W     (FRAC_W),
        .DEFAULT_NAN(DEFAULT_NAN)
    ) u_resolve (
        .x_i   (x_i),
        .y_i   (y_i),
        .xcls_i(cls[0]),
        .ycls_i(cls[1]),
        .xs_i  (sgn[0]),
        .ys_i  (sgn[1]),
        .rm_i  (rm_i),
        .val_o (r_val),
        .inv_o (r_inv),
        .dp_o  (r_dp),
        .nx_o  (r_nx),
        .ny_o  (r_ny)
    );

    always_comb begin
        out_d     = '0;
        out_d.res = r_val;
        out_d.inv = r_inv;
        out_d.dp  = r_dp;
        out_d.nx  = r_nx;
        out_d.ny  = r_ny;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign res_o     = out_q.res;
    assign invalid_o = out_q.inv;
    assign use_dp_o  = out_q.dp;
    assign norm_x_o  = out_q.nx;
    assign norm_y_o  = out_q.ny;

endmodule

// File: rtl/fpsub_special_chk.sv
module fpsub_special_chk #(
    parameter int EXP_W                 = 11,
    parameter int FRAC_W                = 52,
    localparam int W                    = 1 + EXP_W + FRAC_W,
    parameter logic [W-1:0] DEFAULT_NAN = 64'h7FF8_0000_0000_0000
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] x_i,
    input logic [W-1:0] y_i,
    input logic [1:0]   rm_i,
    input logic [W-1:0] res_o,
    input logic         invalid_o,
    input logic         use_dp_o,
    input logic         norm_x_o,
    input logic         norm_y_o
);

    logic x_snan, y_snan, x_zero, y_zero;

    always_comb begin
        x_snan = (&x_i[W-2 -: EXP_W]) && !x_i[FRAC_W-1] && (|x_i[FRAC_W-1:0]);
        y_snan = (&y_i[W-2 -: EXP_W]) && !y_i[FRAC_W-1] && (|y_i[FRAC_W-1:0]);
        x_zero = (x_i[W-2:0] == '0);
        y_zero = (y_i[W-2:0] == '0);
    end

    AST_INVALID_IS_DEFNAN: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |-> (res_o == DEFAULT_NAN)); // R11

    AST_SNAN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (x_snan || y_snan) |=> (invalid_o && res_o == DEFAULT_NAN)); // R1

    AST_DP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        use_dp_o |-> (!invalid_o && res_o == '0)); // R9

    AST_NORM_NEEDS_DP: assert property (@(posedge clk) disable iff (!rst_n)
        (norm_x_o || norm_y_o) |-> use_dp_o); // R9

    AST_ZERO_SIGN_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (x_zero && y_zero && x_i[W-1] == y_i[W-1] && rm_i == 2'b11)
        |=> (res_o == {1'b1, {(W-1){1'b0}}})); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |-> (res_o == '0 && !invalid_o && !use_dp_o)); // R10

endmodule

bind fpsub_special fpsub_special_chk #(
    .EXP_W      (EXP_W),
    .FRAC_W     (FRAC_W),
    .DEFAULT_NAN(DEFAULT_NAN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .x_i      (x_i),
    .y_i      (y_i),
    .rm_i     (rm_i),
    .res_o    (res_o),
    .invalid_o(invalid_o),
    .use_dp_o (use_dp_o),
    .norm_x_o (norm_x_o),
    .norm_y_o (norm_y_o)
);

// File: tb/fpsub_special_tb.sv
module fpsub_special_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W = 64;
    localparam logic [W-1:0] DNAN = 64'h7FF8_0000_0000_0000;

    localparam logic [W-1:0] P1   = 64'h3FF0_0000_0000_0000;
    localparam logic [W-1:0] P2   = 64'h4000_0000_0000_0000;
    localparam logic [W-1:0] N1   = 64'hBFF0_0000_0000_0000;
    localparam logic [W-1:0] PINF = 64'h7FF0_0000_0000_0000;
    localparam logic [W-1:0] NINF = 64'hFFF0_0000_0000_0000;
    localparam logic [W-1:0] QA   = 64'h7FF8_0000_0000_0123;
    localparam logic [W-1:0] QB   = 64'hFFFC_0000_0000_0456;
    localparam logic [W-1:0] SA   = 64'h7FF0_0000_0000_0001;
    localparam logic [W-1:0] SB   = 64'hFFF4_0000_0000_0000;
    localparam logic [W-1:0] PZ   = 64'h0;
    localparam logic [W-1:0] NZ   = 64'h8000_0000_0000_0000;
    localparam logic [W-1:0] PD   = 64'h0000_0000_0000_0001;
    localparam logic [W-1:0] ND   = 64'h8000_0000_0000_0001;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] x_i = '0;
    logic [W-1:0] y_i = '0;
    logic [1:0]   rm_i = 2'b00;
    logic [W-1:0] res_o;
    logic         invalid_o, use_dp_o, norm_x_o, norm_y_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W+3:0] exp_q [$];
    string        tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fpsub_special u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .x_i      (x_i),
        .y_i      (y_i),
        .rm_i     (rm_i),
        .res_o    (res_o),
        .invalid_o(invalid_o),
        .use_dp_o (use_dp_o),
        .norm_x_o (norm_x_o),
        .norm_y_o (norm_y_o)
    );

    task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic [1:0] rm, input logic [W-1:0] er,
                         input logic ei, input logic ed, input logic enx,
                         input logic eny, input string tag);
        @(negedge clk);
        x_i  = x;
        y_i  = y;
        rm_i = rm;
        exp_q.push_back({er, ei, ed, enx, eny});
        tag_q.push_back(tag);
    endtask

    // monitor: outputs settle one edge after the driver's negedge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [W+3:0] e;
                logic [W+3:0] a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {res_o, invalid_o, use_dp_o, norm_x_o, norm_y_o};
                checks++;
                if (a !== e) begin
                    fails++;
                    $display("FAIL %s: got res=%h inv=%b dp=%b nx=%b ny=%b, expected res=%h inv=%b dp=%b nx=%b ny=%b",
                             t, a[W+3:4], a[3], a[2], a[1], a[0],
                             e[W+3:4], e[3], e[2], e[1], e[0]);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        x_i = SA;
        y_i = P1;
        repeat (3) @(negedge clk);
        // R10: reset holds all outputs at zero despite live inputs
        checks++;
        if ({res_o, invalid_o, use_dp_o, norm_x_o, norm_y_o} !== '0) begin
            fails++;
            $display("FAIL R10: got res=%h inv=%b dp=%b, expected all zero",
                     res_o, invalid_o, use_dp_o);
        end
        rst_n = 1'b1;

        // R1: signaling NaNs, including priority over quiet NaN
        drive(SA, P1, 2'b00, DNAN, 1, 0, 0, 0, "R1 snan-x");
        drive(P1, SB, 2'b00, DNAN, 1, 0, 0, 0, "R1 snan-y");
        drive(QA, SB, 2'b00, DNAN, 1, 0, 0, 0, "R1 qnan-snan");
        drive(SB, PINF, 2'b11, DNAN, 1, 0, 0, 0, "R1 snan-inf");
        // R2: quiet NaN propagation
        drive(QA, P1, 2'b00, QA, 0, 0, 0, 0, "R2 qnan-x");
        drive(PINF, QB, 2'b00, QB, 0, 0, 0, 0, "R2 qnan-y");
        drive(QA, QB, 2'b00, QA, 0, 0, 0, 0, "R2 both qnan");
        drive(PZ, QB, 2'b11, QB, 0, 0, 0, 0, "R2 zero-qnan");
        // R3: infinity minus infinity
        drive(PINF, PINF, 2'b00, DNAN, 1, 0, 0, 0, "R3 inf same sign");
        drive(NINF, NINF, 2'b10, DNAN, 1, 0, 0, 0, "R3 -inf same sign");
        drive(PINF, NINF, 2'b00, PINF, 0, 0, 0, 0, "R3 inf opposite");
        // R4: finite/zero minus infinity
        drive(P1, PINF, 2'b00, NINF, 0, 0, 0, 0, "R4 one-inf");
        drive(NZ, NINF, 2'b00, PINF, 0, 0, 0, 0, "R4 zero-neginf");
        drive(ND, PINF, 2'b00, NINF, 0, 0, 0, 0, "R4 denorm-inf");
        // R5: infinity minus finite/zero
        drive(NINF, P2, 2'b00, NINF, 0, 0, 0, 0, "R5 inf-two");
        drive(PINF, PD, 2'b00, PINF, 0, 0, 0, 0, "R5 inf-denorm");
        drive(PINF, NZ, 2'b00, PINF, 0, 0, 0, 0, "R5 inf-zero");
        // R6: zero minus zero, all modes
        drive(PZ, PZ, 2'b00, PZ, 0, 0, 0, 0, "R6 +0-+0 nearest");
        drive(PZ, PZ, 2'b01, PZ, 0, 0, 0, 0, "R6 +0-+0 tozero");
        drive(NZ, NZ, 2'b10, PZ, 0, 0, 0, 0, "R6 -0--0 up");
        drive(PZ, PZ, 2'b11, NZ, 0, 0, 0, 0, "R6 +0-+0 down");
        drive(NZ, NZ, 2'b11, NZ, 0, 0, 0, 0, "R6 -0--0 down");
        drive(PZ, NZ, 2'b11, PZ, 0, 0, 0, 0, "R6 +0--0 down");
        drive(NZ, PZ, 2'b00, NZ, 0, 0, 0, 0, "R6 -0-+0");
        // R7: finite minus zero
        drive(P2, PZ, 2'b00, P2, 0, 0, 0, 0, "R7 two-zero");
        drive(PD, NZ, 2'b11, PD, 0, 0, 0, 0, "R7 denorm-negzero");
        // R8: zero minus finite
        drive(PZ, P1, 2'b00, N1, 0, 0, 0, 0, "R8 zero-one");
        drive(NZ, ND, 2'b00, PD, 0, 0, 0, 0, "R8 zero-negdenorm");
        // R9: datapath pairs and normalisation flags
        drive(P1, P2, 2'b00, '0, 0, 1, 0, 0, "R9 norm-norm");
        drive(PD, N1, 2'b00, '0, 0, 1, 1, 0, "R9 denorm-norm");
        drive(P1, ND, 2'b00, '0, 0, 1, 0, 1, "R9 norm-denorm");
        drive(PD, ND, 2'b00, '0, 0, 1, 1, 1, "R9 denorm-denorm");
        // R10: result of the next pair replaces the last one after one edge
        drive(N1, PINF, 2'b00, NINF, 0, 0, 0, 0, "R10 latency");

        wait (exp_q.size() == 0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule